// File: doc/BRIEF.md
# Restart and Interrupt Vector Unit

This block decides, at each allowed sampling point, whether a hardware interrupt is accepted and which 16-bit restart address the core should branch to. It serves two sources. The first is a software restart instruction carrying a number from 0 to 7. The second is a set of four request lines: one non-maskable trap and three maskable levels. Each maskable level has its own mask bit and is also gated by a shared interrupt-enable flip-flop. The enable and disable commands drive that flip-flop, reset clears it, and the acceptance of any interrupt clears it again.

The core presents an instruction-boundary strobe and a halted flag. Requests are only considered on the strobe, or in any cycle while the core is halted. An accepted interrupt gives a one-cycle taken pulse, a vector address and, if the core was halted, a wake pulse that releases the halt.

The vector output is a one-cycle qualified pulse (`vec_valid_o` with `vec_addr_o`). It has no ready input and applies no back-pressure: the consumer must capture the address in the cycle it is valid. Control and status pins are plain levels or pulses.

Top module: `intr_vector_unit`

## Requirements
- R1: A software restart request with number n gives, one clock later, a one-cycle `vec_valid_o` with `vec_addr_o` = n×8 (0x0000 to 0x0038) and `irq_taken_o` low. This holds whatever the boundary and halted inputs are.
- R2: A trap request present at a sampling point is accepted whatever the enable flip-flop and the mask bits hold, with vector 0x0024.
- R3: The maskable levels give these vectors: `lvl_req_i[0]` (level 5.5) 0x002C, `lvl_req_i[1]` (level 6.5) 0x0034, `lvl_req_i[2]` (level 7.5) 0x003C. On acceptance `irq_taken_o` and `vec_valid_o` both pulse for one cycle, one clock after the sampling edge.
- R4: When several requests are eligible at once, the trap wins, then `lvl_req_i[2]`, then `lvl_req_i[1]`, then `lvl_req_i[0]`.
- R5: Reset clears the enable flip-flop and drives every output to 0. `ien_set_i` sets the flip-flop and `ien_clr_i` clears it, with the clear winning when both are high. The new value is first used one cycle later. While the flip-flop is clear, no maskable level is accepted.
- R6: A maskable level whose `lvl_mask_i` bit is 1 is never accepted, even with the enable flip-flop set.
- R7: Accepting any interrupt, the trap included, clears the enable flip-flop. This clear wins over an `ien_set_i` in the same cycle.
- R8: Requests are sampled only in a cycle where `boundary_i` or `halted_i` is high. In any other cycle they are ignored.
- R9: `irq_taken_o` is never high in two consecutive cycles. The cycle right after an acceptance is not a sampling point, so at most one interrupt is taken per sample.
- R10: `wake_o` pulses together with `irq_taken_o` only when `halted_i` was high at the accepting edge. It never pulses otherwise.
- R11: If a hardware interrupt is accepted in the same cycle as a software restart request, the interrupt vector is produced and the restart request is dropped.
- R12: `vec_addr_o` reads 0 in every cycle where `vec_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction-boundary strobe; enables sampling |
| halted_i | input | 1 | Core is halted; every cycle is a sampling point |
| ien_set_i | input | 1 | Enable command: set the enable flip-flop |
| ien_clr_i | input | 1 | Disable command: clear the enable flip-flop |
| trap_i | input | 1 | Non-maskable trap request |
| lvl_req_i | input | 3 | Maskable requests: bit0 level 5.5, bit1 level 6.5, bit2 level 7.5 |
| lvl_mask_i | input | 3 | Per-level mask; 1 blocks the level |
| swvec_valid_i | input | 1 | Software restart request |
| swvec_num_i | input | 3 | Software restart number n |
| irq_taken_o | output | 1 | One-cycle pulse: a hardware interrupt was accepted |
| wake_o | output | 1 | One-cycle pulse: leave the halted state |
| vec_valid_o | output | 1 | Vector address valid this cycle |
| vec_addr_o | output | 16 | Restart address |

## Verification
On every cycle, the assertions check the cycle-level rules. These are the clear on acknowledge and the command precedence on the enable flip-flop, that the trap is always granted at a sampling point, that no maskable grant happens with the flip-flop clear, and that no taken pulse appears without a sampling point or next to another taken pulse. They also check that wake only comes with a taken pulse after a halted cycle, and that the address is zero when not valid. Only the bench scenarios can show the exact vector values, the full priority order among simultaneous requests, the effect of the mask bits, the one-cycle lag of the enable commands, and the dropping of a software restart that collides with an interrupt.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  // Which source owns the vector produced this cycle.
  typedef enum logic [1:0] {
    VSRC_NONE = 2'd0,
    VSRC_SOFT = 2'd1,
    VSRC_HW   = 2'd2
  } vsrc_e;

  // base + step * idx, all 32-bit; callers narrow to the address width.
  function automatic logic [31:0] step_addr(input logic [31:0] base,
                                            input logic [31:0] step,
                                            input logic [31:0] idx);
    return base + step * idx;
  endfunction

endpackage

// File: rtl/irqv_enable_ff.sv
module irqv_enable_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ack_i,
  output logic ie_o
);

  logic ie_q;

  // Clear sources (acknowledge, disable) dominate the enable command.
  always_ff @(posedge clk) begin
    if (!rst_n)              ie_q <= 1'b0;
    else if (ack_i || clr_i) ie_q <= 1'b0;
    else if (set_i)          ie_q <= 1'b1;
  end

  assign ie_o = ie_q;

  AST_ACK_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !ie_o);                                           // R7
  AST_DISABLE_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !ie_o);                                           // R5
  AST_ENABLE_SETS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i && !ack_i) |=> ie_o);                      // R5
  AST_IE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i && !ack_i) |=> $stable(ie_o));            // R5

endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter #(
  parameter int unsigned NUM_LVL = 3,
  localparam int unsigned IDX_W  = $clog2(NUM_LVL + 1)
) (
  input  logic               sample_i,
  input  logic               ie_i,
  input  logic               trap_i,
  input  logic [NUM_LVL-1:0] lvl_i,
  input  logic [NUM_LVL-1:0] mask_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o   // 0 = trap, k+1 = level k
);

  logic [NUM_LVL-1:0] elig;

  generate
    for (genvar k = 0; k < NUM_LVL; k++) begin : g_elig
      assign elig[k] = lvl_i[k] & ~mask_i[k] & ie_i;
    end
  endgenerate

  // Ascending scan: a higher level overwrites a lower one; trap overrides all.
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    if (sample_i) begin
      for (int k = 0; k < NUM_LVL; k++) begin
        if (elig[k]) begin
          hit_o = 1'b1;
          idx_o = IDX_W'(k + 1);
        end
      end
      if (trap_i) begin
        hit_o = 1'b1;
        idx_o = '0;
      end
    end
  end

  always_comb begin
    AST_NO_GRANT_OFF_SAMPLE: assert (!hit_o || sample_i);                    // R8
    AST_TRAP_ALWAYS_GRANTED: assert (!(sample_i && trap_i) || (hit_o && idx_o == '0)); // R2
    AST_MASKABLE_NEEDS_IE: assert (!(hit_o && idx_o != '0) || ie_i);        // R5
  end

endmodule

// File: rtl/irqv_vec_gen.sv
module irqv_vec_gen
  import irqv_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned NUM_LVL = 3,
  parameter int unsigned SW_CNT  = 8,
  parameter int unsigned SW_STEP = 8,
  parameter int unsigned HW_BASE = 32'h24,
  parameter int unsigned HW_STEP = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_LVL + 1),
  localparam int unsigned SWN_W  = $clog2(SW_CNT)
) (
  input  vsrc_e             src_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [SWN_W-1:0]  num_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [31:0] wide;

  always_comb begin
    unique case (src_i)
      VSRC_HW:   wide = step_addr(32'(HW_BASE), 32'(HW_STEP), 32'(idx_i));
      VSRC_SOFT: wide = step_addr(32'd0, 32'(SW_STEP), 32'(num_i));
      default:   wide = 32'd0;
    endcase
  end

  assign addr_o = wide[ADDR_W-1:0];

endmodule

// File: rtl/intr_vector_unit.sv
module intr_vector_unit
  import irqv_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned NUM_LVL = 3,
  parameter int unsigned SW_CNT  = 8,
  parameter int unsigned SW_STEP = 8,
  parameter int unsigned HW_BASE = 32'h24,
  parameter int unsigned HW_STEP = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_LVL + 1),
  localparam int unsigned SWN_W  = $clog2(SW_CNT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boundary_i,
  input  logic               halted_i,
  input  logic               ien_set_i,
  input  logic               ien_clr_i,
  input  logic               trap_i,
  input  logic [NUM_LVL-1:0] lvl_req_i,
  input  logic [NUM_LVL-1:0] lvl_mask_i,
  input  logic               swvec_valid_i,
  input  logic [SWN_W-1:0]   swvec_num_i,
  output logic               irq_taken_o,
  output logic               wake_o,
  output logic               vec_valid_o,
  output logic [ADDR_W-1:0]  vec_addr_o
);

  logic              ie;
  logic              sample;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  vsrc_e             src;
  logic [ADDR_W-1:0] addr_next;

  logic              taken_q;
  logic              wake_q;
  logic              vvalid_q;
  logic [ADDR_W-1:0] vaddr_q;

  // A sampling point is a boundary or a halted cycle, but never the cycle
  // right after an acceptance.
  assign sample = (boundary_i | halted_i) & ~taken_q;

  irqv_enable_ff u_ie (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ien_set_i),
    .clr_i (ien_clr_i),
    .ack_i (hit),
    .ie_o  (ie)
  );

  irqv_arbiter #(.NUM_LVL(NUM_LVL)) u_arb (
    .sample_i (sample),
    .ie_i     (ie),
    .trap_i   (trap_i),
    .lvl_i    (lvl_req_i),
    .mask_i   (lvl_mask_i),
    .hit_o    (hit),
    .idx_o    (idx)
  );

  // A hardware grant takes the vector slot; a colliding restart is dropped.
  always_comb begin
    if (hit)                src = VSRC_HW;
    else if (swvec_valid_i) src = VSRC_SOFT;
    else                    src = VSRC_NONE;
  end

  irqv_vec_gen #(
    .ADDR_W  (ADDR_W),
    .NUM_LVL (NUM_LVL),
    .SW_CNT  (SW_CNT),
    .SW_STEP (SW_STEP),
    .HW_BASE (HW_BASE),
    .HW_STEP (HW_STEP)
  ) u_vec (
    .src_i  (src),
    .idx_i  (idx),
    .num_i  (swvec_num_i),
    .addr_o (addr_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken_q  <= 1'b0;
      wake_q   <= 1'b0;
      vvalid_q <= 1'b0;
      vaddr_q  <= '0;
    end else begin
      taken_q  <= hit;
      wake_q   <= hit & halted_i;
      vvalid_q <= (src != VSRC_NONE);
      vaddr_q  <= addr_next;
    end
  end

  assign irq_taken_o = taken_q;
  assign wake_o      = wake_q;
  assign vec_valid_o = vvalid_q;
  assign vec_addr_o  = vaddr_q;

  AST_TAKEN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken_o |=> !irq_taken_o);                              // R9
  AST_TAKEN_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken_o |-> $past(boundary_i || halted_i));             // R8
  AST_TAKEN_HAS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken_o |-> vec_valid_o);                               // R3
  AST_WAKE_WITH_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> irq_taken_o);                                    // R10
  AST_WAKE_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(halted_i));                                // R10
  AST_SOFT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && !irq_taken_o) |-> ((vec_addr_o % SW_STEP) == 0)); // R1
  AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid_o |-> (vec_addr_o == '0));                       // R12

endmodule

// File: tb/intr_vector_unit_bench.sv
`timescale 1ns/100ps
module intr_vector_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        boundary, halted, en_set, en_clr, trap, swv;
  logic [2:0]  lvl, mask, swn;
  logic        taken, wake, vv;
  logic [15:0] addr;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  intr_vector_unit u_intr_vector_unit (
    .clk (clk), .rst_n (rst_n),
    .boundary_i (boundary), .halted_i (halted),
    .ien_set_i (en_set), .ien_clr_i (en_clr),
    .trap_i (trap), .lvl_req_i (lvl), .lvl_mask_i (mask),
    .swvec_valid_i (swv), .swvec_num_i (swn),
    .irq_taken_o (taken), .wake_o (wake),
    .vec_valid_o (vv), .vec_addr_o (addr)
  );

  typedef struct packed {
    logic        pre_en;   // 1: enable command before, 0: disable command
    logic        bnd;
    logic        halt;
    logic        trp;
    logic [2:0]  req;
    logic [2:0]  msk;
    logic        sv;
    logic [2:0]  sn;
    logic        e_tk;
    logic        e_wk;
    logic        e_vv;
    logic [15:0] e_addr;
    int          tag;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,3'b000,3'b000,1'b1,3'd5, 1'b0,1'b0,1'b1,16'h0028, 1}, // R1
    '{1'b0,1'b0,1'b0,1'b0,3'b000,3'b000,1'b1,3'd0, 1'b0,1'b0,1'b1,16'h0000, 1}, // R1
    '{1'b0,1'b1,1'b0,1'b0,3'b000,3'b000,1'b1,3'd7, 1'b0,1'b0,1'b1,16'h0038, 1}, // R1
    '{1'b0,1'b1,1'b0,1'b1,3'b000,3'b111,1'b0,3'd0, 1'b1,1'b0,1'b1,16'h0024, 2}, // R2
    '{1'b1,1'b1,1'b0,1'b0,3'b001,3'b000,1'b0,3'd0, 1'b1,1'b0,1'b1,16'h002C, 3}, // R3
    '{1'b1,1'b1,1'b0,1'b0,3'b010,3'b000,1'b0,3'd0, 1'b1,1'b0,1'b1,16'h0034, 3}, // R3
    '{1'b1,1'b1,1'b0,1'b0,3'b100,3'b000,1'b0,3'd0, 1'b1,1'b0,1'b1,16'h003C, 3}, // R3
    '{1'b0,1'b1,1'b0,1'b0,3'b111,3'b000,1'b0,3'd0, 1'b0,1'b0,1'b0,16'h0000, 5}, // R5
    '{1'b1,1'b1,1'b0,1'b1,3'b111,3'b000,1'b0,3'd0, 1'b1,1'b0,1'b1,16'h0024, 4}, // R4
    '{1'b1,1'b1,1'b0,1'b0,3'b111,3'b000,1'b0,3'd0, 1'b1,1'b0,1'b1,16'h003C, 4}, // R4
    '{1'b1,1'b1,1'b0,1'b0,3'b011,3'b000,1'b0,3'd0, 1'b1,1'b0,1'b1,16'h0034, 4}, // R4
    '{1'b1,1'b1,1'b0,1'b0,3'b101,3'b100,1'b0,3'd0, 1'b1,1'b0,1'b1,16'h002C, 6}, // R6
    '{1'b1,1'b1,1'b0,1'b0,3'b111,3'b111,1'b0,3'd0, 1'b0,1'b0,1'b0,16'h0000, 6}, // R6
    '{1'b1,1'b0,1'b0,1'b1,3'b111,3'b000,1'b0,3'd0, 1'b0,1'b0,1'b0,16'h0000, 8}, // R8
    '{1'b1,1'b0,1'b1,1'b0,3'b010,3'b000,1'b0,3'd0, 1'b1,1'b1,1'b1,16'h0034,10}, // R10
    '{1'b0,1'b0,1'b1,1'b1,3'b000,3'b000,1'b0,3'd0, 1'b1,1'b1,1'b1,16'h0024,10}, // R10
    '{1'b1,1'b0,1'b1,1'b0,3'b100,3'b100,1'b0,3'd0, 1'b0,1'b0,1'b0,16'h0000,10}, // R10
    '{1'b1,1'b1,1'b0,1'b0,3'b001,3'b000,1'b1,3'd3, 1'b1,1'b0,1'b1,16'h002C,11}  // R11
  };

  task automatic idle();
    boundary = 0; halted = 0; en_set = 0; en_clr = 0; trap = 0;
    lvl = '0; mask = '0; swv = 0; swn = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Compare {taken, wake, valid, addr}; R12 is covered by every zero-address expectation.
  task automatic chk(input string tag, input logic [18:0] exp);
    logic [18:0] act;
    act = {taken, wake, vv, addr};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual tk/wk/vv/addr=%b/%b/%b/%h expected=%b/%b/%b/%h",
               tag, act[18], act[17], act[16], act[15:0],
               exp[18], exp[17], exp[16], exp[15:0]);
    end
  endtask

  localparam logic [18:0] NONE = 19'd0;

  initial begin
    rst_n = 0;
    idle();
    repeat (3) tick();
    chk("R5 reset outputs", NONE);
    rst_n = 1;
    tick();

    // R5: enable flip-flop starts clear after reset
    boundary = 1; lvl = 3'b001; tick();
    chk("R5 post-reset ie clear", NONE);
    idle(); tick();

    for (int i = 0; i < NV; i++) begin
      idle();
      if (VECS[i].pre_en) en_set = 1; else en_clr = 1;
      tick();
      idle();
      boundary = VECS[i].bnd; halted = VECS[i].halt; trap = VECS[i].trp;
      lvl = VECS[i].req; mask = VECS[i].msk; swv = VECS[i].sv; swn = VECS[i].sn;
      tick();
      chk($sformatf("R%0d vector %0d", VECS[i].tag, i),
          {VECS[i].e_tk, VECS[i].e_wk, VECS[i].e_vv, VECS[i].e_addr});
      idle();
      tick();
      chk($sformatf("R12 idle after vector %0d", i), NONE);
    end

    // R7: acknowledge clears the enable flip-flop
    idle(); en_set = 1; tick();
    idle(); boundary = 1; lvl = 3'b001; tick();
    chk("R7 first accept", {1'b1, 1'b0, 1'b1, 16'h002C});
    idle(); tick();
    boundary = 1; lvl = 3'b001; tick();
    chk("R7 ie cleared by ack", NONE);

    // R7: ack wins over a simultaneous enable command
    idle(); en_set = 1; tick();
    idle(); boundary = 1; lvl = 3'b010; en_set = 1; tick();
    chk("R7 accept with enable", {1'b1, 1'b0, 1'b1, 16'h0034});
    idle(); tick();
    boundary = 1; lvl = 3'b010; tick();
    chk("R7 ack beats enable", NONE);

    // R7: a trap acknowledge clears the flip-flop as well
    idle(); en_set = 1; tick();
    idle(); boundary = 1; trap = 1; tick();
    chk("R7 trap accept", {1'b1, 1'b0, 1'b1, 16'h0024});
    idle(); tick();
    boundary = 1; lvl = 3'b100; tick();
    chk("R7 trap ack clears ie", NONE);

    // R5: disable wins over enable in the same cycle
    idle(); en_set = 1; en_clr = 1; tick();
    idle(); boundary = 1; lvl = 3'b100; tick();
    chk("R5 clear beats set", NONE);

    // R5: enable takes effect one cycle later
    idle(); en_clr = 1; tick();
    idle(); en_set = 1; boundary = 1; lvl = 3'b001; tick();
    chk("R5 enable not yet visible", NONE);
    idle(); boundary = 1; lvl = 3'b001; tick();
    chk("R5 enable visible next cycle", {1'b1, 1'b0, 1'b1, 16'h002C});

    // R9: strobe held with trap held: accept, blocked, accept
    idle(); tick();
    boundary = 1; trap = 1; tick();
    chk("R9 held trap edge1", {1'b1, 1'b0, 1'b1, 16'h0024});
    tick();
    chk("R9 held trap edge2 blocked", NONE);
    tick();
    chk("R9 held trap edge3", {1'b1, 1'b0, 1'b1, 16'h0024});

    // R5: reset mid-run clears the flip-flop
    idle(); en_set = 1; tick();
    idle(); rst_n = 0; tick();
    chk("R5 outputs in reset", NONE);
    rst_n = 1; tick();
    boundary = 1; lvl = 3'b100; tick();
    chk("R5 reset clears ie", NONE);
    idle(); tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule